// File: doc/BRIEF.md
# 64-bit Burst SDRAM Controller

This block sits between a single client and a 16-bit wide SDR SDRAM. The client sees a 64-bit memory. Every client request becomes one fixed burst of four 16-bit beats. Writes are split into beats, and reads are assembled from four beats into one 64-bit word before the block hands it back. Eight active-high byte enables let the client write any subset of the eight bytes. Each pair of enables is inverted and steered onto the upper and lower data mask pins in the beat that carries those two bytes.

After reset, the controller waits a programmable power-up delay and precharges all banks. It then runs two auto-refresh cycles and programs the mode register for bursts of four, sequential order and a CAS latency of two. After that it accepts requests. A free-running interval counter raises a refresh request. That refresh is issued only when no access is in flight, and it wins over a client request that is waiting. Each access activates the row and waits the row-to-column delay. It then issues a read or a write with auto-precharge and pulses `ready` for one cycle when the access is complete.

Top module: `sdr64_ctrl`

## Requirements
- R1: While `rst` is high the block drives `sd_cke` low, the NOP command ({cs_n,ras_n,cas_n,we_n} = 0111), `ready` low and `rdata` zero.
- R2: While `init` is high only NOP is issued. After `init` falls, at least T_PWRUP cycles of NOP pass. Then come PRECHARGE-all (0010, address bit 10 set), AUTO-REFRESH (0001), AUTO-REFRESH, and LOAD-MODE (0000) with address 0x022 and bank 0.
- R3: After initialisation, AUTO-REFRESH commands follow each other at REF_INT cycles, within the length of one access. A refresh is never issued while a row is open.
- R4: The word address splits as column = bits [8:0], row = bits [21:9] and bank = bits [23:22]. ACTIVE (0011) carries row and bank. READ (0101) or WRITE (0100) follows at least T_RCD cycles later, with the column on the low address bits and address bit 10 set for auto-precharge.
- R5: Beat 0 carries data bits [63:48] and beat 3 carries bits [15:0], on four consecutive cycles starting with the WRITE command, with `sd_dq_oe` high. Read beats are assembled in the same order into `rdata`.
- R6: In write beat b, `sd_dqmh` = ~be[7-2b] and `sd_dqml` = ~be[6-2b]. During a READ command both masks are low.
- R7: `ready` is a single-cycle pulse. For a read it comes 6 cycles after the READ command, with the assembled `rdata` valid in the same cycle. For a write it comes T_WR+T_RP+3 cycles after the WRITE command.
- R8: A request that arrives while an access is in progress is held and executed after it. Results come back in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Holds the power-up sequence while the clock is not stable |
| req | input | 1 | One-cycle request pulse |
| addr | input | 24 | 16-bit word address, low two bits zero |
| rnw | input | 1 | 1 = read, 0 = write |
| be | input | 8 | Active-high byte enables for writes |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Assembled read data |
| ready | output | 1 | One-cycle completion pulse |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_a | output | 13 | Multiplexed address |
| sd_ba | output | 2 | Bank address |
| sd_dqml | output | 1 | Lower byte mask |
| sd_dqmh | output | 1 | Upper byte mask |
| sd_dq_out | output | 16 | Data driven to the SDRAM |
| sd_dq_oe | output | 1 | Output enable for `sd_dq_out` |
| sd_dq_in | input | 16 | Data returned by the SDRAM |

## Verification
The bench models the SDRAM at the pins and checks a partial write against earlier contents. A design that swapped the upper and lower masks, or ran the beats in the wrong order, returns bytes in the wrong lanes. It also issues a read one cycle after a write to the same address has started. A controller that dropped or reordered the held request either hangs the scoreboard or returns stale data. Refresh timing and the row state at each refresh are checked across long idle stretches and across runs of accesses. The bench also checks the exact cycle distance from command to `ready`, which catches an off-by-one in the CAS latency capture window or in the write recovery wait.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
    localparam int DQ_W    = 16;
    localparam int BEATS   = 4;
    localparam int DATA_W  = DQ_W * BEATS;
    localparam int BE_W    = DATA_W / 8;
    localparam int COL_W   = 9;
    localparam int ROW_W   = 13;
    localparam int BA_W    = 2;
    localparam int ADDR_W  = COL_W + ROW_W + BA_W;
    localparam int AP_BIT  = 10;
    localparam int CAS_LAT = 2;

    // burst length 4, sequential, CAS latency in [6:4]
    localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'({3'(CAS_LAT), 1'b0, 3'b010});
    localparam logic [ROW_W-1:0] PRE_ALL_A = ROW_W'(1) << AP_BIT;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_ACT = 4'b0011,
        CMD_RD  = 4'b0101,
        CMD_WR  = 4'b0100,
        CMD_PRE = 4'b0010,
        CMD_REF = 4'b0001,
        CMD_MRS = 4'b0000
    } cmd_t;

    typedef enum logic [3:0] {
        ST_PWR, ST_PRE, ST_REF1, ST_REF2, ST_MRS,
        ST_IDLE, ST_RFC, ST_RCD, ST_RD, ST_WR, ST_DAL
    } state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rnw;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] wdata;
    } req_t;

    function automatic logic [COL_W-1:0] col_of(logic [ADDR_W-1:0] a);
        return a[COL_W-1:0];
    endfunction

    function automatic logic [ROW_W-1:0] row_of(logic [ADDR_W-1:0] a);
        return a[COL_W +: ROW_W];
    endfunction

    function automatic logic [BA_W-1:0] bank_of(logic [ADDR_W-1:0] a);
        return a[COL_W+ROW_W +: BA_W];
    endfunction

    function automatic logic [ROW_W-1:0] cas_word(logic [COL_W-1:0] c);
        logic [ROW_W-1:0] w;
        w = '0;
        w[COL_W-1:0] = c;
        w[AP_BIT] = 1'b1;
        return w;
    endfunction

    // beat 0 is the most significant halfword
    function automatic logic [DQ_W-1:0] beat_data(logic [DATA_W-1:0] d, logic [1:0] b);
        return d[(BEATS-1-int'(b))*DQ_W +: DQ_W];
    endfunction

    // returns {dqmh, dqml}
    function automatic logic [1:0] beat_mask(logic [BE_W-1:0] be, logic [1:0] b);
        return ~be[(BEATS-1-int'(b))*2 +: 2];
    endfunction
endpackage

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
    parameter int INTERVAL = 780
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic ack,
    output logic pend
);
    localparam int W = $clog2(INTERVAL + 1);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else begin
            if (ack) pend <= 1'b0;
            if (cnt == W'(INTERVAL - 1)) begin
                cnt  <= '0;
                pend <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sdr_req_hold.sv
module sdr_req_hold
    import sdr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  req_t in,
    input  logic take,
    output logic vld,
    output req_t held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld  <= 1'b0;
            held <= '0;
        end else begin
            if (take) vld <= 1'b0;
            if (req) begin
                vld  <= 1'b1;
                held <= in;
            end
        end
    end
endmodule

// File: rtl/sdr_rd_shift.sv
module sdr_rd_shift #(
    parameter int DQ_W  = 16,
    parameter int BEATS = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cap,
    input  logic [DQ_W-1:0]       din,
    output logic [DQ_W*BEATS-1:0] dout
);
    localparam int W = DQ_W * BEATS;

    always_ff @(posedge clk) begin
        if (rst)      dout <= '0;
        else if (cap) dout <= {dout[W-DQ_W-1:0], din};
    end
endmodule

// File: rtl/sdr64_ctrl.sv
module sdr64_ctrl
    import sdr_pkg::*;
#(
    parameter int T_PWRUP = 20000,
    parameter int T_RP    = 2,
    parameter int T_RCD   = 2,
    parameter int T_RFC   = 7,
    parameter int T_MRD   = 2,
    parameter int T_WR    = 2,
    parameter int REF_INT = 780
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rnw,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ready,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ROW_W-1:0]  sd_a,
    output logic [BA_W-1:0]   sd_ba,
    output logic              sd_dqml,
    output logic              sd_dqmh,
    output logic [DQ_W-1:0]   sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DQ_W-1:0]   sd_dq_in
);
    localparam int CNT_MAX = (T_PWRUP > 64) ? T_PWRUP : 64;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int RD_WAIT = CAS_LAT + BEATS - 1;

    state_t           st;
    logic [CNT_W-1:0] cnt;
    cmd_t             cmd;
    logic [1:0]       dqm;
    req_t             op, hold, req_in;
    logic             hold_vld, take, ref_pend, ref_ack, cap, init_done;
    logic [1:0]       wbeat;

    assign req_in    = '{addr: addr, rnw: rnw, be: be, wdata: wdata};
    assign take      = (st == ST_IDLE) && !ref_pend && hold_vld;
    assign ref_ack   = (st == ST_IDLE) && ref_pend;
    assign cap       = (st == ST_RD) && (cnt <= CNT_W'(BEATS - 1));
    assign init_done = !(st inside {ST_PWR, ST_PRE, ST_REF1, ST_REF2, ST_MRS});
    assign wbeat     = 2'(BEATS - 1) - cnt[1:0];

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign {sd_dqmh, sd_dqml} = dqm;

    sdr_req_hold u_hold (
        .clk(clk), .rst(rst), .req(req), .in(req_in),
        .take(take), .vld(hold_vld), .held(hold)
    );

    sdr_refresh_timer #(.INTERVAL(REF_INT)) u_ref (
        .clk(clk), .rst(rst), .en(init_done), .ack(ref_ack), .pend(ref_pend)
    );

    sdr_rd_shift #(.DQ_W(DQ_W), .BEATS(BEATS)) u_rd (
        .clk(clk), .rst(rst), .cap(cap), .din(sd_dq_in), .dout(rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_PWR;
            cnt       <= CNT_W'(T_PWRUP - 1);
            cmd       <= CMD_NOP;
            sd_cke    <= 1'b0;
            sd_a      <= '0;
            sd_ba     <= '0;
            dqm       <= 2'b00;
            sd_dq_out <= '0;
            sd_dq_oe  <= 1'b0;
            ready     <= 1'b0;
            op        <= '0;
        end else begin
            cmd      <= CMD_NOP;
            ready    <= 1'b0;
            sd_dq_oe <= 1'b0;
            dqm      <= 2'b00;
            sd_cke   <= 1'b1;
            if (cnt != '0) cnt <= cnt - 1'b1;
            if (init) begin
                st  <= ST_PWR;
                cnt <= CNT_W'(T_PWRUP - 1);
            end else begin
                case (st)
                    ST_PWR: if (cnt == '0) begin
                        cmd   <= CMD_PRE;
                        sd_a  <= PRE_ALL_A;
                        st    <= ST_PRE;
                        cnt   <= CNT_W'(T_RP - 1);
                    end
                    ST_PRE: if (cnt == '0) begin
                        cmd <= CMD_REF;
                        st  <= ST_REF1;
                        cnt <= CNT_W'(T_RFC - 1);
                    end
                    ST_REF1: if (cnt == '0) begin
                        cmd <= CMD_REF;
                        st  <= ST_REF2;
                        cnt <= CNT_W'(T_RFC - 1);
                    end
                    ST_REF2: if (cnt == '0) begin
                        cmd   <= CMD_MRS;
                        sd_a  <= MODE_WORD;
                        sd_ba <= '0;
                        st    <= ST_MRS;
                        cnt   <= CNT_W'(T_MRD - 1);
                    end
                    ST_MRS: if (cnt == '0) st <= ST_IDLE;
                    ST_IDLE: begin
                        if (ref_pend) begin
                            cmd <= CMD_REF;
                            st  <= ST_RFC;
                            cnt <= CNT_W'(T_RFC - 1);
                        end else if (hold_vld) begin
                            cmd   <= CMD_ACT;
                            sd_a  <= row_of(hold.addr);
                            sd_ba <= bank_of(hold.addr);
                            op    <= hold;
                            st    <= ST_RCD;
                            cnt   <= CNT_W'(T_RCD - 1);
                        end
                    end
                    ST_RFC: if (cnt == '0) st <= ST_IDLE;
                    ST_RCD: if (cnt == '0) begin
                        sd_a <= cas_word(col_of(op.addr));
                        if (op.rnw) begin
                            cmd <= CMD_RD;
                            st  <= ST_RD;
                            cnt <= CNT_W'(RD_WAIT);
                        end else begin
                            cmd       <= CMD_WR;
                            sd_dq_out <= beat_data(op.wdata, 2'd0);
                            dqm       <= beat_mask(op.be, 2'd0);
                            sd_dq_oe  <= 1'b1;
                            st        <= ST_WR;
                            cnt       <= CNT_W'(BEATS - 2);
                        end
                    end
                    ST_WR: begin
                        sd_dq_out <= beat_data(op.wdata, wbeat);
                        dqm       <= beat_mask(op.be, wbeat);
                        sd_dq_oe  <= 1'b1;
                        if (cnt == '0) begin
                            st  <= ST_DAL;
                            cnt <= CNT_W'(T_WR + T_RP - 1);
                        end
                    end
                    ST_DAL: if (cnt == '0) begin
                        ready <= 1'b1;
                        st    <= ST_IDLE;
                    end
                    ST_RD: if (cnt == '0) begin
                        ready <= 1'b1;
                        st    <= ST_IDLE;
                    end
                    default: st <= ST_PWR;
                endcase
            end
        end
    end
endmodule

// File: rtl/sdr64_ctrl_chk.sv
module sdr64_ctrl_chk
    import sdr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             init,
    input logic             ready,
    input logic             sd_cke,
    input logic             sd_cs_n,
    input logic             sd_ras_n,
    input logic             sd_cas_n,
    input logic             sd_we_n,
    input logic [ROW_W-1:0] sd_a,
    input logic             sd_dqml,
    input logic             sd_dqmh,
    input logic             sd_dq_oe
);
    logic [3:0] c;
    assign c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    a_r7_ready_single: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    a_r2_init_nop: assert property (@(posedge clk) disable iff (rst)
        init |=> (c == CMD_NOP));

    a_r4_auto_pre: assert property (@(posedge clk) disable iff (rst)
        (c == CMD_RD || c == CMD_WR) |-> sd_a[AP_BIT]);

    a_r6_read_unmasked: assert property (@(posedge clk) disable iff (rst)
        (c == CMD_RD) |-> (!sd_dqml && !sd_dqmh));

    a_r1_cke_for_cmd: assert property (@(posedge clk) disable iff (rst)
        (c != CMD_NOP) |-> sd_cke);

    a_r5_oe_with_write: assert property (@(posedge clk) disable iff (rst)
        (c == CMD_WR) |-> sd_dq_oe);

    a_r4_act_gap: assert property (@(posedge clk) disable iff (rst)
        (c == CMD_ACT) |=> (c == CMD_NOP));
endmodule

bind sdr64_ctrl sdr64_ctrl_chk u_chk (.*);

// File: tb/sdr64_ctrl_tb.sv
module sdr64_ctrl_tb;
    import sdr_pkg::*;

    localparam int T_PWRUP = 40;
    localparam int REF_INT = 150;
    localparam int T_RP = 2, T_RCD = 2, T_RFC = 7, T_MRD = 2, T_WR = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1, init = 1'b1, req = 1'b0, rnw = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [BE_W-1:0] be = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic ready, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqml, sd_dqmh, sd_dq_oe;
    logic [ROW_W-1:0] sd_a;
    logic [BA_W-1:0] sd_ba;
    logic [DQ_W-1:0] sd_dq_out;
    logic [DQ_W-1:0] sd_dq_in = '0;

    sdr64_ctrl #(.T_PWRUP(T_PWRUP), .T_RP(T_RP), .T_RCD(T_RCD), .T_RFC(T_RFC),
                 .T_MRD(T_MRD), .T_WR(T_WR), .REF_INT(REF_INT)) u_dut (
        .clk(clk), .rst(rst), .init(init), .req(req), .addr(addr), .rnw(rnw),
        .be(be), .wdata(wdata), .rdata(rdata), .ready(ready), .sd_cke(sd_cke),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_a(sd_a), .sd_ba(sd_ba), .sd_dqml(sd_dqml), .sd_dqmh(sd_dqmh),
        .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    typedef struct {
        logic              rnw;
        logic [ADDR_W-1:0] addr;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] data;
    } item_t;

    item_t sbq[$];
    logic [DATA_W-1:0] shadow [int];
    logic [DQ_W-1:0] mem [int];
    int n_chk = 0, n_err = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // cycle counter and pin-level SDRAM model
    int cyc = 0;
    always @(posedge clk) cyc++;

    int init_idx = 0, init_rel = -1, last_ref = -1, n_ref = 0, n_act = 0;
    int act_cyc [4];
    logic [ROW_W-1:0] open_row [4];
    bit bank_open [4];
    int rd_ph = 99, rd_base = 0, wr_ph = 99, wr_base = 0, rw_cyc = 0;
    bit prev_ready = 1'b0;
    logic [3:0] pc;
    cmd_t init_seq [4] = '{CMD_PRE, CMD_REF, CMD_REF, CMD_MRS};

    always @(negedge clk) begin
        pc = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        if (rd_ph < 99) rd_ph++;
        if (wr_ph < 99) wr_ph++;
        if (!rst && pc != CMD_NOP) begin
            if (init_idx < 4) begin
                // R2: init command order, power-up wait, mode word
                chk(pc == init_seq[init_idx], "R2 init order", 64'(pc), 64'(init_seq[init_idx]));
                if (init_idx == 0) begin
                    chk(init_rel >= 0 && cyc - init_rel >= T_PWRUP, "R2 power-up wait", 64'(cyc - init_rel), 64'(T_PWRUP));
                    chk(sd_a[AP_BIT], "R2 precharge all", 64'(sd_a), 64'(PRE_ALL_A));
                end
                if (init_idx == 3)
                    chk(sd_a == 13'h022 && sd_ba == '0, "R2 mode word", 64'(sd_a), 64'h22);
                init_idx++;
            end else if (pc == CMD_ACT) begin
                chk(!bank_open[sd_ba], "R4 act on open bank", 64'(sd_ba), 64'hff);
                bank_open[sd_ba] = 1'b1;
                open_row[sd_ba] = sd_a;
                act_cyc[sd_ba] = cyc;
                n_act++;
            end else if (pc == CMD_RD || pc == CMD_WR) begin
                int k;
                k = int'({sd_ba, open_row[sd_ba], sd_a[COL_W-1:0]});
                chk(bank_open[sd_ba] && cyc - act_cyc[sd_ba] >= T_RCD, "R4 tRCD", 64'(cyc - act_cyc[sd_ba]), 64'(T_RCD));
                chk(sd_a[AP_BIT], "R4 auto-precharge bit", 64'(sd_a), 64'(1 << AP_BIT));
                chk(sbq.size() > 0 && k == int'(sbq[0].addr), "R4 address split", 64'(k),
                    sbq.size() > 0 ? 64'(sbq[0].addr) : 64'hffff_ffff);
                bank_open[sd_ba] = 1'b0;
                rw_cyc = cyc;
                if (pc == CMD_RD) begin
                    chk(!sd_dqml && !sd_dqmh, "R6 read masks", 64'({sd_dqmh, sd_dqml}), 64'h0);
                    rd_ph = 0; rd_base = k;
                end else begin
                    wr_ph = 0; wr_base = k;
                end
            end else if (pc == CMD_REF) begin
                // R3: no open row, interval near REF_INT
                chk(!(bank_open[0] | bank_open[1] | bank_open[2] | bank_open[3]), "R3 refresh with row open", 64'h1, 64'h0);
                if (last_ref >= 0)
                    chk((cyc - last_ref) >= REF_INT - 20 && (cyc - last_ref) <= REF_INT + 20,
                        "R3 refresh interval", 64'(cyc - last_ref), 64'(REF_INT));
                last_ref = cyc;
                n_ref++;
            end
        end
        // R5/R6: write beats with masks
        if (wr_ph <= 3 && sbq.size() > 0) begin
            logic [1:0] mexp;
            logic [DQ_W-1:0] old, nw;
            mexp = ~sbq[0].be[(3 - wr_ph)*2 +: 2];
            chk(sd_dq_oe, "R5 dq_oe during beat", 64'(sd_dq_oe), 64'h1);
            chk({sd_dqmh, sd_dqml} == mexp, "R6 beat masks", 64'({sd_dqmh, sd_dqml}), 64'(mexp));
            old = mem.exists(wr_base + wr_ph) ? mem[wr_base + wr_ph] : '0;
            nw = old;
            if (!sd_dqml) nw[7:0] = sd_dq_out[7:0];
            if (!sd_dqmh) nw[15:8] = sd_dq_out[15:8];
            mem[wr_base + wr_ph] = nw;
        end
        if (rd_ph >= 2 && rd_ph <= 5)
            sd_dq_in = mem.exists(rd_base + rd_ph - 2) ? mem[rd_base + rd_ph - 2] : '0;
        // scoreboard monitor
        if (!rst && ready) begin
            chk(!prev_ready, "R7 ready width", 64'h2, 64'h1);
            if (sbq.size() == 0) begin
                chk(1'b0, "R8 ready without request", 64'h1, 64'h0);
            end else begin
                item_t it;
                it = sbq.pop_front();
                if (it.rnw) begin
                    chk(cyc - rw_cyc == CAS_LAT + 4, "R7 read latency", 64'(cyc - rw_cyc), 64'(CAS_LAT + 4));
                    chk(rdata == it.data, "R5 read data", rdata, it.data);
                end else begin
                    chk(cyc - rw_cyc == T_WR + T_RP + 3, "R7 write latency", 64'(cyc - rw_cyc), 64'(T_WR + T_RP + 3));
                end
            end
        end
        prev_ready = ready;
    end

    function automatic logic [ADDR_W-1:0] mk(input int b, input int r, input int c);
        return {BA_W'(b), ROW_W'(r), COL_W'(c)};
    endfunction

    task automatic issue(input logic [ADDR_W-1:0] a, input bit r, input logic [7:0] b, input logic [63:0] d);
        item_t it;
        logic [63:0] cur;
        cur = shadow.exists(int'(a)) ? shadow[int'(a)] : '0;
        if (!r) begin
            for (int i = 0; i < 8; i++) if (b[i]) cur[i*8 +: 8] = d[i*8 +: 8];
            shadow[int'(a)] = cur;
        end
        it.rnw = r; it.addr = a; it.be = b; it.data = cur;
        sbq.push_back(it);
        @(negedge clk);
        req = 1'b1; addr = a; rnw = r; be = b; wdata = d;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        while (sbq.size() != 0 && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk(sbq.size() == 0, "R8 completion", 64'(sbq.size()), 64'h0);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [ADDR_W-1:0] a0, b0, c0, d0, e0, f0;
        bit quiet;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!sd_cke, "R1 cke low", 64'(sd_cke), 64'h0);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_NOP, "R1 nop",
            64'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 64'(CMD_NOP));
        chk(!ready && rdata == '0, "R1 ready and rdata", rdata, 64'h0);
        rst = 1'b0;
        // R2: init held high gives only NOP
        quiet = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} != CMD_NOP) quiet = 1'b0;
        end
        chk(quiet, "R2 quiet while init", 64'(quiet), 64'h1);
        init = 1'b0;
        init_rel = cyc;
        for (int i = 0; i < 200 && init_idx < 4; i++) @(negedge clk);
        chk(init_idx == 4, "R2 init complete", 64'(init_idx), 64'h4);
        repeat (10) @(negedge clk);

        a0 = mk(0, 5, 'h10);
        b0 = mk(3, 8191, 'h1fc);
        c0 = mk(1, 0, 0);
        d0 = mk(2, 77, 'h40);
        e0 = mk(1, 300, 8);
        f0 = mk(0, 6, 'h10);

        // R4/R5: full write and read back
        issue(a0, 0, 8'hff, 64'h0123_4567_89ab_cdef); wait_done();
        issue(a0, 1, 8'h00, 64'h0); wait_done();
        // R6: partial write merges with old contents
        issue(a0, 0, 8'ha5, 64'hfedc_ba98_7654_3210); wait_done();
        issue(a0, 1, 8'h00, 64'h0); wait_done();
        // several banks, rows and columns
        issue(b0, 0, 8'hff, 64'hdead_beef_cafe_f00d); wait_done();
        issue(c0, 0, 8'h0f, 64'h1111_2222_3333_4444); wait_done();
        issue(d0, 0, 8'hc0, 64'h9999_8888_7777_6666); wait_done();
        issue(b0, 0, 8'h00, 64'h5555_5555_5555_5555); wait_done();
        issue(b0, 1, 8'h00, 64'h0); wait_done();
        issue(c0, 1, 8'h00, 64'h0); wait_done();
        issue(d0, 1, 8'h00, 64'h0); wait_done();

        // R8: second request arrives while first is active
        begin
            int na;
            na = n_act;
            issue(e0, 0, 8'h3c, 64'habcd_ef01_2345_6789);
            for (int i = 0; i < 40 && n_act == na; i++) @(negedge clk);
            issue(e0, 1, 8'h00, 64'h0);
            wait_done();
            na = n_act;
            issue(f0, 0, 8'hff, 64'h0f0f_0f0f_f0f0_f0f0);
            for (int i = 0; i < 40 && n_act == na; i++) @(negedge clk);
            issue(a0, 1, 8'h00, 64'h0);
            wait_done();
            issue(f0, 1, 8'h00, 64'h0);
            wait_done();
        end

        // R3: idle long enough to see several refreshes
        repeat (3 * REF_INT + 20) @(negedge clk);
        chk(n_ref >= 3, "R3 refresh count", 64'(n_ref), 64'h3);

        // traffic that runs across refresh points
        for (int i = 0; i < 30; i++) begin
            issue(mk(i % 4, 100 + i, (i * 4) % 512), 0, 8'(8'h81 ^ (i * 7)), {32'(i * 3), 32'(~i)});
            wait_done();
            issue(mk(i % 4, 100 + i, (i * 4) % 512), 1, 8'h00, 64'h0);
            wait_done();
        end
        chk(sbq.size() == 0, "R8 queue drained", 64'(sbq.size()), 64'h0);
        finish_run();
    end
endmodule